// File: doc/BRIEF.md
# DIMM Row Boundary and Attribute Calculator

This block turns the presence-detect bytes of two memory module slots into the row configuration bytes a memory controller needs. Firmware or a presence-detect reader presents the bytes of slot 0 with a one-cycle strobe. It then presents slot 1 the same way. For each slot the block checks the module for a supported type, the clock-speed grade, the per-side size and the page geometry. It splits the density byte into the two side sizes and chains those sizes into six cumulative boundary bytes in 32 MB units. It also forms one attribute byte per slot that encodes page size and sidedness.

Processing is one slot per strobe. A non-fatal condition, an unequal pair of sides, silently makes the module single-sided. A fatal condition freezes the block with an error flag and a reason code until reset. After the second slot is accepted without fault, the done flag rises and the results stay fixed.

Top module: `dimm_rowcalc`

## Requirements
- R1: A slot whose type byte is not 0x04 is empty. It adds 0 to the boundaries, receives attribute 0xFF and raises no error.
- R2: The side-1 size is the weight of the highest set bit of the density byte times 4 MB. Its boundary contribution is that size divided by 32 MB, rounded down.
- R3: With a bank count above 1 and only one density bit set, side 2 equals side 1. With a bank count of 1, side 2 is 0.
- R4: With a bank count above 1 and further density bits below the side-1 bit, side 2 is forced to 0 and no error is raised.
- R5: A populated slot whose cycle-time byte is not 0x75, or whose access-time byte is not 0x54, is fatal with code 2.
- R6: A populated slot whose side 1 is below 32 MB or above 256 MB is fatal with code 3.
- R7: The boundaries chain in order. B0 is slot 0 side 1. B1 is B0 plus slot 0 side 2. B2 is B1 plus slot 1 side 1. B3 is B2 plus slot 1 side 2. B4 and B5 copy B3. The entries are packed with B0 in the low byte of `row_bound`.
- R8: Page size in KB is (2^cols × width) / 8192, rounded down. A bank count of 1 encodes 2, 4, 8 and 16 KB as 0xF0, 0xF1, 0xF2 and 0xF3. A bank count of 2 encodes them as 0x00, 0x11, 0x22 and 0x33. The slot 0 attribute is the low byte of `row_attr`.
- R9: A bank count other than 1 or 2 is fatal with code 1. Any other page size is fatal with code 4. When several faults apply, the priority is timing, then size, then bank count, then page.
- R10: A fatal fault sets `err` and latches `err_code`, keeps `done` low, and leaves all boundary and attribute bytes unchanged. Later strobes are ignored.
- R11: The first strobe after reset is slot 0 and the second is slot 1. `done` rises on the clock edge that accepts slot 1. Strobes after `done` change no output.
- R12: After reset, all boundaries, attributes, `done`, `err` and `err_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_valid | input | 1 | One-cycle strobe: the slot bytes are valid |
| spd_mem_type | input | 8 | Memory type byte |
| spd_density | input | 8 | Row density byte, one bit per 4 MB weight |
| spd_banks | input | 8 | Module bank (side) count |
| spd_cols | input | 8 | Column address bit count |
| spd_width | input | 8 | Module data width in bits |
| spd_cycle | input | 8 | Minimum cycle-time byte |
| spd_access | input | 8 | Access-time byte |
| row_bound | output | 48 | Six cumulative boundary bytes, B0 in bits 7:0 |
| row_attr | output | 16 | Attribute byte of slot 0 (bits 7:0) and slot 1 (bits 15:8) |
| done | output | 1 | Both slots processed without fault |
| err | output | 1 | A fatal fault was found |
| err_code | output | 3 | Fault reason: 0 none, 1 banks, 2 timing, 3 size, 4 page |

## Verification
The silent single-sided downgrade and the fatal size check can both apply to one module in the same evaluation. The bench provokes this with a two-bank module whose density byte holds a 512 MB top bit plus a lower bit. The result is judged correct only if the size code is latched, `done` stays low and no boundary byte moves, which shows that the downgrade did not let the module through. Combined faults of timing with size, and of bank count with page, check the same arbitration in the other priority pairs.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] SDR_TYPE   = 8'h04;
  localparam logic [7:0] CYC_OK     = 8'h75;
  localparam logic [7:0] ACC_OK     = 8'h54;
  localparam logic [7:0] EMPTY_ATTR = 8'hFF;

  // reason codes, ordered as seen at the port
  typedef enum logic [2:0] {
    FAULT_NONE   = 3'd0,
    FAULT_BANKS  = 3'd1,
    FAULT_TIMING = 3'd2,
    FAULT_SIZE   = 3'd3,
    FAULT_PAGE   = 3'd4
  } fault_e;

  typedef struct packed {
    logic       fatal;
    fault_e     fault;
    logic [7:0] inc_a;   // side-1 contribution, 32 MB units
    logic [7:0] inc_b;   // side-2 contribution, 32 MB units
    logic [7:0] attr;
  } slot_res_t;
endpackage

// File: rtl/rc_side_decode.sv
module rc_side_decode
  import rc_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic [DW-1:0] density,
  input  logic          dual,
  output logic [DW-1:0] side_a_w,
  output logic [DW-1:0] side_b_w,
  output logic          asym
);
  logic [DW-1:0] rest;
  logic [DW-1:0] b_raw;

  always_comb begin
    side_a_w = '0;
    // ascending scan: the highest set bit is the last one to win
    for (int i = 0; i < DW; i++) begin
      if (density[i]) side_a_w = {{(DW-1){1'b0}}, 1'b1} << i;
    end
    rest = density & ~side_a_w;
    if (!dual)                b_raw = '0;
    else if (rest == '0)      b_raw = side_a_w;
    else if ($onehot(rest))   b_raw = rest;
    else                      b_raw = '0;
    asym     = dual && (b_raw != '0) && (b_raw != side_a_w);
    side_b_w = asym ? '0 : b_raw;
  end
endmodule

// File: rtl/rc_slot_check.sv
module rc_slot_check
  import rc_pkg::*;
(
  input  logic [7:0] mem_type,
  input  logic [7:0] density,
  input  logic [7:0] banks,
  input  logic [7:0] cols,
  input  logic [7:0] width,
  input  logic [7:0] cycle,
  input  logic [7:0] access,
  output slot_res_t  res
);
  logic        populated;
  logic        dual;
  logic        asym;
  logic [7:0]  wa;
  logic [7:0]  wb;
  logic [9:0]  mb_a;
  logic [9:0]  mb_b;
  logic        timing_bad;
  logic        size_bad;
  logic        banks_bad;
  logic        page_bad;
  logic [39:0] page_kb;
  logic [1:0]  page_idx;
  fault_e      fault;

  always_comb dual = banks > 8'd1;

  rc_side_decode #(.DW(BYTE_W)) u_side (
    .density  (density),
    .dual     (dual),
    .side_a_w (wa),
    .side_b_w (wb),
    .asym     (asym)
  );

  always_comb begin
    populated  = (mem_type == SDR_TYPE);
    timing_bad = (cycle != CYC_OK) || (access != ACC_OK);
    mb_a       = {wa, 2'b00};
    mb_b       = {wb, 2'b00};
    size_bad   = (mb_a < 10'd32) || (mb_a > 10'd256);
    banks_bad  = (banks != 8'd1) && (banks != 8'd2);

    page_kb  = ({32'd0, width} << cols[4:0]) >> 13;
    page_bad = 1'b0;
    page_idx = 2'd0;
    case (page_kb)
      40'd2:   page_idx = 2'd0;
      40'd4:   page_idx = 2'd1;
      40'd8:   page_idx = 2'd2;
      40'd16:  page_idx = 2'd3;
      default: page_bad = 1'b1;
    endcase
    if (|cols[7:5]) page_bad = 1'b1;

    fault = FAULT_NONE;
    if (populated) begin
      if (timing_bad)      fault = FAULT_TIMING;
      else if (size_bad)   fault = FAULT_SIZE;
      else if (banks_bad)  fault = FAULT_BANKS;
      else if (page_bad)   fault = FAULT_PAGE;
    end

    res.fault = fault;
    res.fatal = (fault != FAULT_NONE);
    if (populated) begin
      res.inc_a = 8'(mb_a >> 5);
      res.inc_b = 8'(mb_b >> 5);
      res.attr  = (banks == 8'd1) ? {4'hF, 2'b00, page_idx}
                                  : {2'b00, page_idx, 2'b00, page_idx};
    end else begin
      res.inc_a = '0;
      res.inc_b = '0;
      res.attr  = EMPTY_ATTR;
    end
  end

  // R4: an unequal pair never survives as a second side
  always_comb begin
    if (asym) a_r4_asym_dropped: assert (side_b_eq_zero_or_a(wa, wb));
  end

  function automatic logic side_b_eq_zero_or_a(input logic [7:0] a, input logic [7:0] b);
    return (b == 8'd0) || (b == a);
  endfunction
endmodule

// File: rtl/rc_seq.sv
module rc_seq
  import rc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   slot_valid,
  input  logic   fatal,
  input  fault_e fault,
  output logic   load_a,
  output logic   load_b,
  output logic   done,
  output logic   err,
  output fault_e err_code
);
  logic   slot_q, slot_d;
  logic   done_q, done_d;
  logic   err_q, err_d;
  fault_e code_q, code_d;
  logic   take;

  always_comb begin
    take   = slot_valid && !done_q && !err_q;
    slot_d = slot_q;
    done_d = done_q;
    err_d  = err_q;
    code_d = code_q;
    load_a = 1'b0;
    load_b = 1'b0;
    if (take) begin
      if (fatal) begin
        err_d  = 1'b1;
        code_d = fault;
      end else if (!slot_q) begin
        load_a = 1'b1;
        slot_d = 1'b1;
      end else begin
        load_b = 1'b1;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= FAULT_NONE;
    end else if (take) begin
      slot_q <= slot_d;
      done_q <= done_d;
      err_q  <= err_d;
      code_q <= code_d;
    end
  end

  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q && $stable(code_q));
  a_r10_no_done_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_q && done_q));
  a_r9_code_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> code_q != FAULT_NONE);
  a_r11_done_after_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(slot_q));
endmodule

// File: rtl/rc_row_regs.sv
module rc_row_regs
  import rc_pkg::*;
#(
  parameter int unsigned N_BOUND = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_a,
  input  logic                          load_b,
  input  logic [7:0]                    inc_a,
  input  logic [7:0]                    inc_b,
  input  logic [7:0]                    attr,
  output logic [N_BOUND-1:0][BYTE_W-1:0] bound,
  output logic [1:0][BYTE_W-1:0]         attr_o
);
  localparam int unsigned N_SPARE = N_BOUND - 4;

  logic [3:0][7:0] b_q, b_d;
  logic [1:0][7:0] a_q, a_d;
  logic [7:0]      top_d;

  always_comb begin
    b_d   = b_q;
    a_d   = a_q;
    top_d = b_q[1] + inc_a + inc_b;
    if (load_a) begin
      b_d[0] = inc_a;
      b_d[1] = inc_a + inc_b;
      a_d[0] = attr;
    end
    if (load_b) begin
      b_d[2] = b_q[1] + inc_a;
      b_d[3] = top_d;
      a_d[1] = attr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      a_q <= '0;
    end else if (load_a || load_b) begin
      b_q <= b_d;
      a_q <= a_d;
    end
  end

  assign bound[3:0] = b_q;
  assign attr_o     = a_q;

  for (genvar g = 0; g < N_SPARE; g++) begin : g_spare
    logic [7:0] sp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sp_q <= '0;
      else if (load_b) sp_q <= top_d;
    end
    assign bound[4+g] = sp_q;

    a_r7_spare_copy: assert property (@(posedge clk) disable iff (!rst_n)
      load_b |=> sp_q == b_q[3]);
  end

  a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |=> (b_q[3] >= b_q[2]) && (b_q[2] >= b_q[1]));
endmodule

// File: rtl/dimm_rowcalc.sv
module dimm_rowcalc
  import rc_pkg::*;
#(
  parameter int unsigned N_BOUND = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_valid,
  input  logic [7:0]           spd_mem_type,
  input  logic [7:0]           spd_density,
  input  logic [7:0]           spd_banks,
  input  logic [7:0]           spd_cols,
  input  logic [7:0]           spd_width,
  input  logic [7:0]           spd_cycle,
  input  logic [7:0]           spd_access,
  output logic [N_BOUND*8-1:0] row_bound,
  output logic [15:0]          row_attr,
  output logic                 done,
  output logic                 err,
  output logic [2:0]           err_code
);
  logic [1:0]                    rst_sync;
  logic                          rst_int_n;
  slot_res_t                     res;
  logic                          load_a;
  logic                          load_b;
  fault_e                        code;
  logic [N_BOUND-1:0][BYTE_W-1:0] bound;
  logic [1:0][BYTE_W-1:0]         attr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rc_slot_check u_check (
    .mem_type (spd_mem_type),
    .density  (spd_density),
    .banks    (spd_banks),
    .cols     (spd_cols),
    .width    (spd_width),
    .cycle    (spd_cycle),
    .access   (spd_access),
    .res      (res)
  );

  rc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .slot_valid (slot_valid),
    .fatal      (res.fatal),
    .fault      (res.fault),
    .load_a     (load_a),
    .load_b     (load_b),
    .done       (done),
    .err        (err),
    .err_code   (code)
  );

  rc_row_regs #(.N_BOUND(N_BOUND)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_a (load_a),
    .load_b (load_b),
    .inc_a  (res.inc_a),
    .inc_b  (res.inc_b),
    .attr   (res.attr),
    .bound  (bound),
    .attr_o (attr_w)
  );

  assign row_bound = bound;
  assign row_attr  = attr_w;
  assign err_code  = code;

  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> $stable(row_bound) && $stable(row_attr));
  a_r10_frozen_on_err: assert property (@(posedge clk) disable iff (!rst_int_n)
    err |=> $stable(row_bound) && $stable(row_attr));
endmodule

// File: tb/dimm_rowcalc_tb_top.sv
module dimm_rowcalc_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic            slot_valid;
  logic [7:0]      ty, dn, bk, co, wd, cy, ac;
  logic [5:0][7:0] row_bound;
  logic [1:0][7:0] row_attr;
  logic            done, err;
  logic [2:0]      err_code;

  dimm_rowcalc dut_i (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid),
    .spd_mem_type(ty), .spd_density(dn), .spd_banks(bk), .spd_cols(co),
    .spd_width(wd), .spd_cycle(cy), .spd_access(ac),
    .row_bound(row_bound), .row_attr(row_attr),
    .done(done), .err(err), .err_code(err_code)
  );

  typedef struct {
    string           tag;
    logic [5:0][7:0] bnd;
    logic [1:0][7:0] attr;
    logic            dn;
    logic            er;
    logic [2:0]      cd;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  logic [5:0][7:0] m_b;
  logic [1:0][7:0] m_a;
  logic            m_done, m_err, m_slot;
  logic [2:0]      m_code;

  task automatic model_slot(input logic [7:0] t, d, b, c, w, cyc, acc,
                            output logic fat, output logic [2:0] cd,
                            output int u1, output int u2, output logic [7:0] at);
    int s1 = 0;
    int s2 = 0;
    longint kb;
    int idx;
    fat = 1'b0; cd = 3'd0; u1 = 0; u2 = 0; at = 8'hFF;
    if (t != 8'h04) return;                          // R1
    for (int wt = 512; wt >= 1; wt = wt / 2)         // R2
      if ((int'(d) & wt) != 0) begin s1 = wt; break; end
    if (b > 1 && int'(d) == s1) s2 = s1;             // R3; any extra bit drops side 2 (R4)
    if (c > 31) kb = -1;
    else kb = (longint'(w) << c) / 8 / 1024;
    if (cyc != 8'h75 || acc != 8'h54)        cd = 3'd2;
    else if (s1 * 4 < 32 || s1 * 4 > 256)    cd = 3'd3;
    else if (b != 1 && b != 2)               cd = 3'd1;
    else if (kb != 2 && kb != 4 && kb != 8 && kb != 16) cd = 3'd4;
    fat = (cd != 3'd0);
    idx = (kb == 2) ? 0 : (kb == 4) ? 1 : (kb == 8) ? 2 : 3;
    at  = (b == 1) ? 8'(8'hF0 + idx) : 8'(idx * 8'h11);
    u1  = s1 * 4 / 32;
    u2  = s2 * 4 / 32;
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.tag = tag; e.bnd = m_b; e.attr = m_a; e.dn = m_done; e.er = m_err; e.cd = m_code;
    q.push_back(e);
  endtask

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_b = '0; m_a = '0; m_done = 0; m_err = 0; m_slot = 0; m_code = 0;
    push_exp("R12 reset state");
  endtask

  task automatic apply(input string tag, input logic [7:0] t, d, b, c, w, cyc, acc);
    logic fat; logic [2:0] cd; int u1, u2; logic [7:0] at;
    @(negedge clk);
    ty = t; dn = d; bk = b; co = c; wd = w; cy = cyc; ac = acc;
    slot_valid = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0;
    model_slot(t, d, b, c, w, cyc, acc, fat, cd, u1, u2, at);
    if (!m_done && !m_err) begin
      if (fat) begin
        m_err = 1'b1; m_code = cd;
      end else if (!m_slot) begin
        m_b[0] = 8'(u1); m_b[1] = 8'(u1 + u2); m_a[0] = at; m_slot = 1'b1;
      end else begin
        m_b[2] = 8'(int'(m_b[1]) + u1);
        m_b[3] = 8'(int'(m_b[1]) + u1 + u2);
        m_b[4] = m_b[3]; m_b[5] = m_b[3];
        m_a[1] = at; m_done = 1'b1;
      end
    end
    push_exp(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (row_bound !== e.bnd) begin
          errors++;
          $display("FAIL %s bounds: actual=%h expected=%h", e.tag, row_bound, e.bnd);
        end
        checks++;
        if (row_attr !== e.attr) begin
          errors++;
          $display("FAIL %s attrs: actual=%h expected=%h", e.tag, row_attr, e.attr);
        end
        checks++;
        if (done !== e.dn || err !== e.er || err_code !== e.cd) begin
          errors++;
          $display("FAIL %s status: actual done=%b err=%b code=%0d expected done=%b err=%b code=%0d",
                   e.tag, done, err, err_code, e.dn, e.er, e.cd);
        end
      end
    end
  end

  task automatic lit_check(input string tag, input logic [47:0] eb, input logic [15:0] ea);
    wait (q.size() == 0);
    @(negedge clk);
    checks++;
    if (row_bound !== eb || row_attr !== ea) begin
      errors++;
      $display("FAIL %s literal: actual=%h/%h expected=%h/%h", tag, row_bound, row_attr, eb, ea);
    end
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [7:0] CY = 8'h75;
  localparam logic [7:0] AC = 8'h54;

  initial begin
    rst_n = 1'b0; slot_valid = 1'b0;
    ty = 0; dn = 0; bk = 0; co = 0; wd = 0; cy = 0; ac = 0;

    // R1 R2 R3 R7 R8: symmetric dual, then empty slot 1
    do_reset();
    apply("R3 dual symmetric slot0", 8'h04, 8'h10, 8'd2, 8'd9, 8'd64, CY, AC);
    apply("R1 empty slot1", 8'h02, 8'h10, 8'd2, 8'd9, 8'd64, CY, AC);
    lit_check("R7 chain with empty slot", 48'h04_04_04_04_04_02, 16'hFF_11);
    apply("R11 strobe after done ignored", 8'h04, 8'h08, 8'd1, 8'd8, 8'd64, CY, AC);

    // R2 R7 R8: single 256 MB then dual 32 MB
    do_reset();
    apply("R8 single 2KB slot0", 8'h04, 8'h40, 8'd1, 8'd8, 8'd64, CY, AC);
    apply("R7 dual 8KB slot1", 8'h04, 8'h08, 8'd2, 8'd10, 8'd64, CY, AC);
    lit_check("R7 chain two modules", 48'h0A_0A_0A_09_08_08, 16'h22_F0);

    // R4 asymmetric downgrade, three-bit density, R8 16KB codes
    do_reset();
    apply("R4 asymmetric downgraded", 8'h04, 8'h18, 8'd2, 8'd11, 8'd64, CY, AC);
    apply("R8 single 16KB slot1", 8'h04, 8'h20, 8'd1, 8'd11, 8'd64, CY, AC);
    do_reset();
    apply("R4 three density bits", 8'h04, 8'h1C, 8'd2, 8'd9, 8'd64, CY, AC);
    apply("R1 empty slot1 after R4", 8'h00, 8'h00, 8'd0, 8'd0, 8'd0, 8'h00, 8'h00);

    // R5 timing fault, later strobes ignored (R10)
    do_reset();
    apply("R5 bad cycle time", 8'h04, 8'h10, 8'd1, 8'd9, 8'd64, 8'h70, AC);
    apply("R10 strobe after fault", 8'h04, 8'h10, 8'd1, 8'd9, 8'd64, CY, AC);
    do_reset();
    apply("R5 bad access time", 8'h04, 8'h10, 8'd1, 8'd9, 8'd64, CY, 8'h60);

    // R6 size limits, fault on slot 1 after good slot 0
    do_reset();
    apply("R6 good slot0", 8'h04, 8'h10, 8'd1, 8'd9, 8'd64, CY, AC);
    apply("R6 slot1 16MB too small", 8'h04, 8'h04, 8'd1, 8'd9, 8'd64, CY, AC);
    apply("R10 slot strobe ignored", 8'h04, 8'h10, 8'd1, 8'd9, 8'd64, CY, AC);
    do_reset();
    apply("R6 512MB too large", 8'h04, 8'h80, 8'd1, 8'd9, 8'd64, CY, AC);
    do_reset();
    apply("R6 downgrade with size fault", 8'h04, 8'h82, 8'd2, 8'd9, 8'd64, CY, AC);

    // R9 bank and page faults and priority
    do_reset();
    apply("R9 timing over size", 8'h04, 8'h04, 8'd1, 8'd9, 8'd64, 8'h00, AC);
    do_reset();
    apply("R9 banks over page", 8'h04, 8'h10, 8'd3, 8'd11, 8'd72, CY, AC);
    do_reset();
    apply("R9 zero banks", 8'h04, 8'h10, 8'd0, 8'd9, 8'd64, CY, AC);
    do_reset();
    apply("R9 page 18KB", 8'h04, 8'h10, 8'd1, 8'd11, 8'd72, CY, AC);
    do_reset();
    apply("R9 page huge cols", 8'h04, 8'h10, 8'd2, 8'd40, 8'd64, CY, AC);

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule